// File: doc/BRIEF.md
# Dual-Lane Registered Bidirectional Bus Transceiver

This block is a 16-bit bidirectional transceiver built as two independent 8-bit lanes. Each lane carries data in two directions: from port A to port B, and from port B to port A. Each direction holds one storage element that works in one of three ways.

- **Transparent:** while the path's latch enable is high, the input passes straight through.
- **Latched:** a falling edge of the latch enable captures the input, whatever level the shared clock has.
- **Clocked:** a rising edge of the shared transfer clock loads the input while the latch enable is low.

Every port is modelled as three separate vectors: data in, data out and output enable. Whether a port drives depends on three things: its direction's active-low enable, one master active-low enable, and a power-good input. Power-good holds every port floating until it has been seen.

The block runs on a fast system clock. The transfer clock, the latch enables and power-good are asynchronous inputs, so each passes through a two-flop synchronizer. Edges are detected on the synchronized copies. In transparent mode the data path is purely combinational. The enable gating is also combinational once power-good has been synchronized.

A per-lane contention flag reports when both ports of a lane would drive at the same time. That combination is not a supported use.

Top module: `xcvrTop`

## Requirements
- R1: After reset, all four stores hold zero. No output enable is set until `pwrGood` has been high at two consecutive rising edges of `clk`. The enables follow the other controls from the cycle after that second edge.
- R2: While `masterOeN` is 1, every bit of `aOe` and `bOe` is 0, whatever the other controls are.
- R3: Port B of lane L drives (`bOe` bits L*8..L*8+7 all 1) exactly when power-good has been synchronized, `masterOeN` is 0 and `oeAbN[L]` is 0. Port A of lane L drives under the same condition with `oeBaN[L]`. Lane L occupies data bits L*8 to L*8+7.
- R4: Once `latchAbEn[L]` has been high through two `clk` edges, `bOut` of lane L equals `aIn` of lane L combinationally.
- R5: A falling edge of `latchAbEn[L]` captures lane L of `aIn` into the A-to-B store. This holds with `busClk` high or low.
- R6: A rising edge of `busClk` while `latchAbEn[L]` is low loads lane L of `aIn` into the A-to-B store. The new value appears on `bOut` after three `clk` edges.
- R7: While the latch enable stays low and `busClk` has no rising edge, the path output holds its stored value. This holds whether `busClk` rests high or low, and however the input changes. A falling `busClk` edge loads nothing.
- R8: The B-to-A path behaves in the same way as R4 to R7, using `latchBaEn`, `bIn` and `aOut`.
- R9: The lanes are independent. One `busClk` rising edge loads every path whose latch enable is low, in both lanes, and leaves transparent paths transparent.
- R10: `contention[L]` is 1 exactly when port A and port B of lane L both drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all asynchronous controls |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrGood | input | 1 | Supply-good indication; every port floats until it has been seen |
| busClk | input | 1 | Shared transfer clock; its rising edge loads the latched paths |
| masterOeN | input | 1 | Master output enable for all ports, active low |
| latchAbEn | input | 2 | Per-lane latch enable for the A-to-B path; high means transparent |
| latchBaEn | input | 2 | Per-lane latch enable for the B-to-A path; high means transparent |
| oeAbN | input | 2 | Per-lane enable for driving port B, active low |
| oeBaN | input | 2 | Per-lane enable for driving port A, active low |
| aIn | input | 16 | Data received on port A |
| bIn | input | 16 | Data received on port B |
| aOut | output | 16 | Data presented to port A |
| aOe | output | 16 | Per-bit drive enable for port A |
| bOut | output | 16 | Data presented to port B |
| bOe | output | 16 | Per-bit drive enable for port B |
| contention | output | 2 | Per-lane flag: both ports of the lane are driving |

## Verification
Each result arrives a different number of `clk` edges after its stimulus:

- Enables follow `masterOeN`, `oeAbN` and `oeBaN` combinationally.
- Power-good reaches the enables after two edges; the bench samples between those two edges and after the second one to pin this down.
- A transparent path follows its input two edges after the latch enable rises.
- A stored value reaches the output three edges after a latch-enable fall or a `busClk` rise.

The bench changes one input at a falling edge of `clk`. It then lets four rising edges pass before sampling at the next falling edge. Every pipelined result has therefore settled, and no further edge is pending when the bench compares.

// File: rtl/xcvrPkg.sv
package xcvrPkg;

  // Per-lane strobes passed from control to datapath
  typedef struct packed {
    logic passAb;  // A-to-B path transparent
    logic loadAb;  // A-to-B store loads this cycle
    logic passBa;  // B-to-A path transparent
    logic loadBa;  // B-to-A store loads this cycle
    logic driveA;  // port A of this lane drives
    logic driveB;  // port B of this lane drives
  } laneStrobe_t;

endpackage

// File: rtl/xcvrSync.sv
// Two-flop synchronizer with one extra stage kept for edge detection
module xcvrSync (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic level,
  output logic prev
);
  logic meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta  <= 1'b0;
      level <= 1'b0;
      prev  <= 1'b0;
    end else begin
      meta  <= asyncIn;
      level <= meta;
      prev  <= level;
    end
  end
endmodule

// File: rtl/xcvrCtrl.sv
module xcvrCtrl #(
  parameter int LANES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrGood,
  input  logic busClk,
  input  logic masterOeN,
  input  logic [LANES-1:0] latchAbEn,
  input  logic [LANES-1:0] latchBaEn,
  input  logic [LANES-1:0] oeAbN,
  input  logic [LANES-1:0] oeBaN,
  output xcvrPkg::laneStrobe_t [LANES-1:0] strobes,
  output logic [LANES-1:0] contention
);
  logic pgMeta, pgSafe;
  logic clkLvl, clkPrev, clkRise;
  logic portsLive;

  // Power-good is synchronized; ports stay floating until it lands
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgMeta <= 1'b0;
      pgSafe <= 1'b0;
    end else begin
      pgMeta <= pwrGood;
      pgSafe <= pgMeta;
    end
  end

  xcvrSync uClkSync (
    .clk(clk), .rstN(rstN), .asyncIn(busClk), .level(clkLvl), .prev(clkPrev)
  );
  assign clkRise   = clkLvl & ~clkPrev;
  assign portsLive = pgSafe & ~masterOeN;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic abLvl, abPrev, abFall;
    logic baLvl, baPrev, baFall;

    xcvrSync uAbSync (
      .clk(clk), .rstN(rstN), .asyncIn(latchAbEn[l]), .level(abLvl), .prev(abPrev)
    );
    xcvrSync uBaSync (
      .clk(clk), .rstN(rstN), .asyncIn(latchBaEn[l]), .level(baLvl), .prev(baPrev)
    );

    assign abFall = abPrev & ~abLvl;
    assign baFall = baPrev & ~baLvl;

    // A store tracks its input while transparent, captures on the falling
    // latch edge, and otherwise loads only on a transfer-clock rise
    assign strobes[l].passAb = abLvl;
    assign strobes[l].loadAb = abLvl | abFall | (clkRise & ~abLvl);
    assign strobes[l].passBa = baLvl;
    assign strobes[l].loadBa = baLvl | baFall | (clkRise & ~baLvl);
    assign strobes[l].driveB = portsLive & ~oeAbN[l];
    assign strobes[l].driveA = portsLive & ~oeBaN[l];
    assign contention[l]     = portsLive & ~oeAbN[l] & ~oeBaN[l];
  end
endmodule

// File: rtl/xcvrDatapath.sv
module xcvrDatapath #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic clk,
  input  logic rstN,
  input  xcvrPkg::laneStrobe_t [LANES-1:0] strobes,
  input  logic [BUS_W-1:0] aIn,
  input  logic [BUS_W-1:0] bIn,
  output logic [BUS_W-1:0] aOut,
  output logic [BUS_W-1:0] aOe,
  output logic [BUS_W-1:0] bOut,
  output logic [BUS_W-1:0] bOe
);
  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [LANE_W-1:0] abStore, baStore;
    logic [LANE_W-1:0] aLane, bLane;

    assign aLane = aIn[l*LANE_W +: LANE_W];
    assign bLane = bIn[l*LANE_W +: LANE_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        abStore <= '0;
        baStore <= '0;
      end else begin
        if (strobes[l].loadAb) abStore <= aLane;
        if (strobes[l].loadBa) baStore <= bLane;
      end
    end

    // Transparent mode bypasses the store combinationally
    assign bOut[l*LANE_W +: LANE_W] = strobes[l].passAb ? aLane : abStore;
    assign aOut[l*LANE_W +: LANE_W] = strobes[l].passBa ? bLane : baStore;
    assign bOe[l*LANE_W +: LANE_W]  = {LANE_W{strobes[l].driveB}};
    assign aOe[l*LANE_W +: LANE_W]  = {LANE_W{strobes[l].driveA}};
  end
endmodule

// File: rtl/xcvrTop.sv
module xcvrTop #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrGood,
  input  logic busClk,
  input  logic masterOeN,
  input  logic [LANES-1:0] latchAbEn,
  input  logic [LANES-1:0] latchBaEn,
  input  logic [LANES-1:0] oeAbN,
  input  logic [LANES-1:0] oeBaN,
  input  logic [BUS_W-1:0] aIn,
  input  logic [BUS_W-1:0] bIn,
  output logic [BUS_W-1:0] aOut,
  output logic [BUS_W-1:0] aOe,
  output logic [BUS_W-1:0] bOut,
  output logic [BUS_W-1:0] bOe,
  output logic [LANES-1:0] contention
);
  xcvrPkg::laneStrobe_t [LANES-1:0] strobes;

  xcvrCtrl #(.LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .busClk(busClk),
    .masterOeN(masterOeN), .latchAbEn(latchAbEn), .latchBaEn(latchBaEn),
    .oeAbN(oeAbN), .oeBaN(oeBaN), .strobes(strobes), .contention(contention)
  );

  xcvrDatapath #(.LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );
endmodule

// File: rtl/xcvrChecker.sv
module xcvrChecker #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int BUS_W = LANES * LANE_W
) (
  input logic clk,
  input logic rstN,
  input logic pwrGood,
  input logic busClk,
  input logic masterOeN,
  input logic [LANES-1:0] latchAbEn,
  input logic [LANES-1:0] latchBaEn,
  input logic [LANES-1:0] oeAbN,
  input logic [LANES-1:0] oeBaN,
  input logic [BUS_W-1:0] aIn,
  input logic [BUS_W-1:0] bIn,
  input logic [BUS_W-1:0] aOut,
  input logic [BUS_W-1:0] aOe,
  input logic [BUS_W-1:0] bOut,
  input logic [BUS_W-1:0] bOe,
  input logic [LANES-1:0] contention
);
  // Cycles since reset, saturating, so history checks skip the reset window
  logic [2:0] sinceRst;
  logic warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end
  assign warm = (sinceRst > 3'd5);

  assert_float_before_pg_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pwrGood, 2) |-> (aOe == '0 && bOe == '0));

  assert_master_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    masterOeN |-> (aOe == '0 && bOe == '0));

  for (genvar l = 0; l < LANES; l++) begin : gLane
    assert_b_needs_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
      (|bOe[l*LANE_W +: LANE_W]) |-> (!oeAbN[l] && !masterOeN));

    assert_a_needs_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
      (|aOe[l*LANE_W +: LANE_W]) |-> (!oeBaN[l] && !masterOeN));

    assert_pass_ab_R4: assert property (@(posedge clk) disable iff (!rstN)
      (warm && $past(latchAbEn[l], 2)) |->
        (bOut[l*LANE_W +: LANE_W] == aIn[l*LANE_W +: LANE_W]));

    assert_pass_ba_R8: assert property (@(posedge clk) disable iff (!rstN)
      (warm && $past(latchBaEn[l], 2)) |->
        (aOut[l*LANE_W +: LANE_W] == bIn[l*LANE_W +: LANE_W]));

    assert_hold_ab_R7: assert property (@(posedge clk) disable iff (!rstN)
      (warm && !$past(latchAbEn[l], 1) && !$past(latchAbEn[l], 2) &&
       !$past(latchAbEn[l], 3) && !$past(latchAbEn[l], 4) &&
       $past(busClk, 1) == $past(busClk, 2) &&
       $past(busClk, 2) == $past(busClk, 3) &&
       $past(busClk, 3) == $past(busClk, 4)) |->
        $stable(bOut[l*LANE_W +: LANE_W]));

    assert_contention_R10: assert property (@(posedge clk) disable iff (!rstN)
      contention[l] |-> ((|aOe[l*LANE_W +: LANE_W]) && (|bOe[l*LANE_W +: LANE_W])));
  end
endmodule

bind xcvrTop xcvrChecker #(.LANES(LANES), .LANE_W(LANE_W)) uChk (.*);

// File: tb/sim_xcvrTop.sv
module sim_xcvrTop;
  localparam int LANES = 2;
  localparam int LW    = 8;
  localparam int BW    = LANES * LW;

  logic clk = 1'b0;
  logic rstN, pwrGood, busClk, masterOeN;
  logic [LANES-1:0] latchAbEn, latchBaEn, oeAbN, oeBaN;
  logic [BW-1:0] aIn, bIn, aOut, aOe, bOut, bOe;
  logic [LANES-1:0] contention;

  int checks = 0;
  int fails  = 0;
  bit pgOn   = 1'b0;
  logic [LW-1:0] abExp [LANES];
  logic [LW-1:0] baExp [LANES];

  always #2 clk = ~clk;

  xcvrTop u0 (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .busClk(busClk),
    .masterOeN(masterOeN), .latchAbEn(latchAbEn), .latchBaEn(latchBaEn),
    .oeAbN(oeAbN), .oeBaN(oeBaN), .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe), .contention(contention)
  );

  task automatic compare(string tag, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Expected port values computed from the requirements
  task automatic checkAll(string tag);
    logic [BW-1:0] eA, eB, eAOe, eBOe;
    logic [BW-1:0] eCon;
    eCon = '0;
    for (int l = 0; l < LANES; l++) begin
      bit dA, dB;
      eB[l*LW +: LW] = latchAbEn[l] ? aIn[l*LW +: LW] : abExp[l];
      eA[l*LW +: LW] = latchBaEn[l] ? bIn[l*LW +: LW] : baExp[l];
      dB = pgOn && !masterOeN && !oeAbN[l];
      dA = pgOn && !masterOeN && !oeBaN[l];
      eBOe[l*LW +: LW] = {LW{dB}};
      eAOe[l*LW +: LW] = {LW{dA}};
      eCon[l] = dA && dB;
    end
    compare(tag, "bOut", bOut, eB);
    compare(tag, "aOut", aOut, eA);
    compare(tag, "bOe", bOe, eBOe);
    compare(tag, "aOe", aOe, eAOe);
    compare(tag, "contention", {{(BW-LANES){1'b0}}, contention}, eCon);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setLatch(bit dirAb, int l, bit v);
    if (dirAb) begin
      if (latchAbEn[l] && !v) abExp[l] = aIn[l*LW +: LW];
      latchAbEn[l] = v;
    end else begin
      if (latchBaEn[l] && !v) baExp[l] = bIn[l*LW +: LW];
      latchBaEn[l] = v;
    end
    settle();
  endtask

  task automatic raiseBusClk();
    busClk = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (!latchAbEn[l]) abExp[l] = aIn[l*LW +: LW];
      if (!latchBaEn[l]) baExp[l] = bIn[l*LW +: LW];
    end
    settle();
  endtask

  task automatic lowerBusClk();
    busClk = 1'b0;
    settle();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; pwrGood = 1'b0; busClk = 1'b0; masterOeN = 1'b0;
    latchAbEn = '0; latchBaEn = '0; oeAbN = '0; oeBaN = '1;
    aIn = 16'h5AC3; bIn = 16'h3C96;
    for (int l = 0; l < LANES; l++) begin abExp[l] = '0; baExp[l] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    checkAll("R1");                         // reset: stores zero, nothing drives

    // R1: power-good takes two edges to reach the enables
    pwrGood = 1'b1;
    @(posedge clk); @(negedge clk);
    compare("R1", "bOe one edge after pg", bOe, '0);
    @(posedge clk); @(negedge clk);
    pgOn = 1'b1;
    compare("R1", "bOe two edges after pg", bOe, '1);
    checkAll("R1");

    // R2: master enable overrides everything
    masterOeN = 1'b1; oeBaN = '0;
    settle(); checkAll("R2");
    masterOeN = 1'b0; oeBaN = '1;
    settle(); checkAll("R3");

    // R4: transparent A-to-B on lane 0
    setLatch(1, 0, 1'b1);
    aIn = 16'hA1B2; settle(); checkAll("R4");

    // R9: transfer-clock rise loads lane 1 only, lane 0 stays transparent
    raiseBusClk(); checkAll("R9");

    // R5: latch-enable fall captures with busClk held high
    aIn = 16'h77E4; settle();
    setLatch(1, 0, 1'b0); checkAll("R5");

    // R7: hold with busClk high, then low, input moving
    aIn = 16'h0F0F; settle(); checkAll("R7");
    lowerBusClk(); checkAll("R7");
    aIn = 16'hF00F; settle(); checkAll("R7");

    // R6: rising transfer clock loads both lanes
    raiseBusClk(); checkAll("R6");
    lowerBusClk();

    // R8: B-to-A direction
    oeAbN = '1; oeBaN = '0;
    setLatch(0, 1, 1'b1);
    bIn = 16'hC0DE; settle(); checkAll("R8");
    setLatch(0, 1, 1'b0); checkAll("R8");
    bIn = 16'h1234; settle(); checkAll("R8");
    raiseBusClk(); checkAll("R8");
    lowerBusClk();

    // R10: contention when both directions of a lane drive
    oeAbN = '0; settle(); checkAll("R10");
    oeAbN = 2'b01; settle(); checkAll("R10");
    oeAbN = 2'b10; oeBaN = 2'b01; settle(); checkAll("R3");

    // Constrained random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      int l;
      op = $urandom_range(0, 6);
      l  = $urandom_range(0, LANES - 1);
      case (op)
        0: begin aIn = BW'($urandom); settle(); checkAll("R7"); end
        1: begin bIn = BW'($urandom); settle(); checkAll("R8"); end
        2: begin setLatch(1, l, ~latchAbEn[l]); checkAll("R5"); end
        3: begin setLatch(0, l, ~latchBaEn[l]); checkAll("R8"); end
        4: begin
             if (busClk) lowerBusClk(); else raiseBusClk();
             checkAll("R6");
           end
        5: begin
             oeAbN = LANES'($urandom); oeBaN = LANES'($urandom);
             settle(); checkAll("R10");
           end
        default: begin
             masterOeN = ($urandom_range(0, 3) == 0);
             settle(); checkAll("R2");
           end
      endcase
    end
    finishRun();
  end
endmodule